// File: doc/BRIEF.md
# Schedule Run-State and Halt Tracker

This block follows whether a host controller's two list schedules, one asynchronous and one periodic (frame-driven), are currently running. Each clock it samples the run/stop, async-enable, periodic-enable and doorbell bits from the command register, the current frame index, and an idle indication from each schedule engine. From these it keeps one state register per schedule and drives an async-running flag, a periodic-running flag and a halted flag. It also produces a one-cycle doorbell acknowledge pulse. The command register uses that pulse to clear the doorbell bit, and the interrupt unit uses it as the async-advance event.

A schedule that is disabled while its engine is still busy enters a draining state. It leaves that state when the engine reports idle. The periodic schedule starts and stops only on frame boundaries, where the low three bits of the frame index are zero. The halted flag is raised only when run/stop is clear and both schedules have really reached the off state. Traversal of the lists and all memory traffic belong to the engines and are outside this block.

Top module: `sched_run_tracker`

## Requirements
- R1: A schedule counts as enabled only when run/stop and its own enable bit are both 1. With run/stop at 0, neither state ever leaves off, whatever the enable bits say.
- R2: The async state becomes on (encoding 01) at the first clock edge at which the async schedule is enabled, whether it was off or draining before.
- R3: At an edge where the async schedule is not enabled and its state is on, the state goes to off (00) if the async engine reports idle and to draining (10) if it does not. A draining state goes to off at the first edge where the engine reports idle.
- R4: The periodic state moves from off to on, and leaves on, only at clock edges where frame index bits 2:0 are zero. On those edges it follows the same on/off/draining rules as the async state. A draining periodic state may go to off at any edge where the periodic engine reports idle, and may return to on only at a boundary.
- R5: The async-running flag is 1 exactly when the async state is not off, and the periodic-running flag is 1 exactly when the periodic state is not off. Each flag changes in the same cycle as its state.
- R6: The halted flag is 0 one edge after run/stop is sampled at 1.
- R7: The halted flag becomes 1 at the edge where run/stop is 0 and both states become (or already are) off. It then stays 1 until run/stop is set.
- R8: When the doorbell bit is 1 at an edge where the async state is on, the acknowledge output is 1 for exactly the next cycle. It is never 1 on two consecutive cycles, and it stays 0 when the doorbell is set while the async state is not on.
- R9: A synchronous reset forces both states to off, both running flags to 0, halted to 1 and the acknowledge output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| run_stop | input | 1 | Run/stop bit of the command register |
| async_en | input | 1 | Async schedule enable bit |
| periodic_en | input | 1 | Periodic schedule enable bit |
| doorbell | input | 1 | Async-advance doorbell bit |
| frame_idx | input | FRAME_W | Current frame index (microframe count) |
| async_idle | input | 1 | Async engine has no transaction in progress |
| periodic_idle | input | 1 | Periodic engine has no transaction in progress |
| async_state | output | 2 | Async state: 00 off, 01 on, 10 draining |
| periodic_state | output | 2 | Periodic state: 00 off, 01 on, 10 draining |
| async_sts | output | 1 | Async schedule running flag |
| periodic_sts | output | 1 | Periodic schedule running flag |
| halted | output | 1 | Controller halted flag |
| doorbell_ack | output | 1 | One-cycle doorbell acknowledge / async-advance event |

## Verification
Two events can land in the same cycle: a doorbell acknowledge and the shutdown of the async schedule. The bench sets the doorbell and clears async-enable on the same drive edge while the async state is on. It then expects the acknowledge pulse and the state change to off to appear together, followed by no second pulse. A second overlap joins the halt decision with a periodic frame boundary. Run/stop is dropped while the periodic state is on and the frame index is off-boundary. The bench checks that halted stays low until the boundary edge, and that it rises in exactly the cycle in which the periodic state reaches off.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    S_OFF   = 2'b00,
    S_ON    = 2'b01,
    S_DRAIN = 2'b10
  } sched_st_t;
endpackage

// File: rtl/sched_lane.sv
module sched_lane
  import sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      step_ok,
  input  logic      idle,
  output sched_st_t state_q,
  output sched_st_t state_n,
  output logic      running
);
  always_comb begin
    state_n = state_q;
    case (state_q)
      S_OFF:   if (enable && step_ok) state_n = S_ON;
      S_ON:    if (!enable && step_ok) state_n = idle ? S_OFF : S_DRAIN;
      S_DRAIN: begin
        if (enable && step_ok) state_n = S_ON;
        else if (idle)         state_n = S_OFF;
      end
      default: state_n = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_OFF;
      running <= 1'b0;
    end else begin
      state_q <= state_n;
      running <= (state_n != S_OFF);
    end
  end
endmodule

// File: rtl/sched_halt.sv
module sched_halt (
  input  logic clk,
  input  logic rst,
  input  logic run_stop,
  input  logic async_off_n,
  input  logic periodic_off_n,
  output logic halted
);
  logic halted_n;

  always_comb begin
    halted_n = halted;
    if (run_stop)                         halted_n = 1'b0;
    else if (async_off_n && periodic_off_n) halted_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) halted <= 1'b1;
    else     halted <= halted_n;
  end
endmodule

// File: rtl/sched_doorbell.sv
module sched_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic doorbell,
  input  logic async_on,
  output logic ack
);
  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= doorbell && async_on && !ack;
  end
endmodule

// File: rtl/sched_run_tracker.sv
module sched_run_tracker
  import sched_pkg::*;
#(
  parameter int FRAME_W = 14,
  parameter int SUB_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_stop,
  input  logic               async_en,
  input  logic               periodic_en,
  input  logic               doorbell,
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic               async_idle,
  input  logic               periodic_idle,
  output logic [1:0]         async_state,
  output logic [1:0]         periodic_state,
  output logic               async_sts,
  output logic               periodic_sts,
  output logic               halted,
  output logic               doorbell_ack
);
  localparam int HI_W = FRAME_W - SUB_W;

  sched_st_t a_q, a_n, p_q, p_n;
  logic      frame_edge;

  assign frame_edge = (frame_idx[SUB_W-1:0] == '0);

  generate
    if (HI_W > 0) begin : g_hi
      logic unused_frame_hi;
      assign unused_frame_hi = ^frame_idx[FRAME_W-1:SUB_W];
    end
  endgenerate

  sched_lane u_async (
    .clk(clk), .rst(rst),
    .enable(run_stop && async_en),
    .step_ok(1'b1),
    .idle(async_idle),
    .state_q(a_q), .state_n(a_n), .running(async_sts)
  );

  sched_lane u_periodic (
    .clk(clk), .rst(rst),
    .enable(run_stop && periodic_en),
    .step_ok(frame_edge),
    .idle(periodic_idle),
    .state_q(p_q), .state_n(p_n), .running(periodic_sts)
  );

  sched_halt u_halt (
    .clk(clk), .rst(rst), .run_stop(run_stop),
    .async_off_n(a_n == S_OFF),
    .periodic_off_n(p_n == S_OFF),
    .halted(halted)
  );

  sched_doorbell u_bell (
    .clk(clk), .rst(rst), .doorbell(doorbell),
    .async_on(a_q == S_ON),
    .ack(doorbell_ack)
  );

  assign async_state    = a_q;
  assign periodic_state = p_q;
endmodule

module sched_run_tracker_chk #(
  parameter int FRAME_W = 14,
  parameter int SUB_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               run_stop,
  input logic               async_en,
  input logic               doorbell,
  input logic [FRAME_W-1:0] frame_idx,
  input logic               async_idle,
  input logic [1:0]         async_state,
  input logic [1:0]         periodic_state,
  input logic               async_sts,
  input logic               periodic_sts,
  input logic               halted,
  input logic               doorbell_ack
);
  // R1
  no_run_stays_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_stop && async_state == 2'b00) |=> async_state == 2'b00);
  // R3
  async_off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(run_stop && async_en) && async_idle && async_state != 2'b00) |=> async_state == 2'b00);
  // R4
  periodic_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (periodic_state != $past(periodic_state) &&
     (periodic_state == 2'b01 || $past(periodic_state) == 2'b01))
    |-> $past(frame_idx[SUB_W-1:0]) == '0);
  // R5
  sts_tracks_state_chk: assert property (@(posedge clk) disable iff (rst)
    (async_sts == (async_state != 2'b00)) && (periodic_sts == (periodic_state != 2'b00)));
  // R6
  run_clears_halt_chk: assert property (@(posedge clk) disable iff (rst)
    run_stop |=> !halted);
  // R7
  halt_needs_off_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (async_state == 2'b00 && periodic_state == 2'b00));
  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    doorbell_ack |=> !doorbell_ack);
  // R8
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(doorbell_ack) |-> $past(doorbell && async_state == 2'b01));
endmodule

bind sched_run_tracker sched_run_tracker_chk #(.FRAME_W(FRAME_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst(rst), .run_stop(run_stop), .async_en(async_en),
  .doorbell(doorbell), .frame_idx(frame_idx), .async_idle(async_idle),
  .async_state(async_state), .periodic_state(periodic_state),
  .async_sts(async_sts), .periodic_sts(periodic_sts),
  .halted(halted), .doorbell_ack(doorbell_ack)
);

// File: tb/sched_run_tracker_tb.sv
`timescale 1ns/1ps
module sched_run_tracker_tb;
  localparam int FW = 14;

  logic          clk = 1'b0;
  logic          rst, run_stop, async_en, periodic_en, doorbell;
  logic [FW-1:0] frame_idx;
  logic          async_idle, periodic_idle;
  logic [1:0]    async_state, periodic_state;
  logic          async_sts, periodic_sts, halted, doorbell_ack;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sched_run_tracker #(.FRAME_W(FW), .SUB_W(3)) u_dut (
    .clk(clk), .rst(rst), .run_stop(run_stop), .async_en(async_en),
    .periodic_en(periodic_en), .doorbell(doorbell), .frame_idx(frame_idx),
    .async_idle(async_idle), .periodic_idle(periodic_idle),
    .async_state(async_state), .periodic_state(periodic_state),
    .async_sts(async_sts), .periodic_sts(periodic_sts),
    .halted(halted), .doorbell_ack(doorbell_ack)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run_stop = 0; async_en = 0; periodic_en = 0; doorbell = 0;
    frame_idx = '0; async_idle = 1; periodic_idle = 1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 async_state", async_state, 0);
    check("R9 periodic_state", periodic_state, 0);
    check("R9 halted", halted, 1);
    check("R9 ack", doorbell_ack, 0);
    run_stop = 1; async_en = 1; periodic_en = 1;
    step(1);
    check("R2 async on", async_state, 1);
    rst = 1'b1;
    step(1);
    check("R9 mid reset async", async_state, 0);
    check("R9 mid reset sts", async_sts, 0);
    check("R9 mid reset halted", halted, 1);
    rst = 1'b0;
  endtask

  task automatic t_no_run();
    do_reset();
    async_en = 1; periodic_en = 1;
    step(3);
    check("R1 async off", async_state, 0);
    check("R1 periodic off", periodic_state, 0);
    check("R1 halted", halted, 1);
  endtask

  task automatic t_async();
    do_reset();
    run_stop = 1; async_en = 1;
    step(1);
    check("R2 async on", async_state, 1);
    check("R5 async sts", async_sts, 1);
    check("R6 halted low", halted, 0);
    async_idle = 0; async_en = 0;
    step(1);
    check("R3 draining", async_state, 2);
    check("R5 sts during drain", async_sts, 1);
    async_en = 1;
    step(1);
    check("R2 drain to on", async_state, 1);
    async_en = 0;
    step(1);
    check("R3 draining again", async_state, 2);
    async_idle = 1;
    step(1);
    check("R3 drained off", async_state, 0);
    check("R5 sts off", async_sts, 0);
    check("R7 halt stays low with run", halted, 0);
  endtask

  task automatic t_periodic();
    do_reset();
    run_stop = 1; periodic_en = 1; frame_idx = 14'd3;
    step(2);
    check("R4 no start off boundary", periodic_state, 0);
    frame_idx = 14'd8;
    step(1);
    check("R4 start on boundary", periodic_state, 1);
    check("R5 periodic sts", periodic_sts, 1);
    periodic_en = 0; frame_idx = 14'd9;
    step(2);
    check("R4 no stop off boundary", periodic_state, 1);
    periodic_idle = 0; frame_idx = 14'd16;
    step(1);
    check("R4 drain at boundary", periodic_state, 2);
    frame_idx = 14'd17; periodic_idle = 1;
    step(1);
    check("R4 drain exit any cycle", periodic_state, 0);
  endtask

  task automatic t_halt();
    do_reset();
    run_stop = 1; async_en = 1; periodic_en = 1; async_idle = 0;
    step(1);
    check("R2 both on async", async_state, 1);
    check("R4 both on periodic", periodic_state, 1);
    run_stop = 0; frame_idx = 14'd5;
    step(1);
    check("R3 async drains on stop", async_state, 2);
    check("R7 not halted while busy", halted, 0);
    async_idle = 1;
    step(1);
    check("R3 async off", async_state, 0);
    check("R7 not halted periodic on", halted, 0);
    frame_idx = 14'd24;
    step(1);
    check("R4 periodic off at boundary", periodic_state, 0);
    check("R7 halted same cycle", halted, 1);
    frame_idx = 14'd25;
    step(2);
    check("R7 halted holds", halted, 1);
    run_stop = 1;
    step(1);
    check("R6 run clears halt", halted, 0);
    check("R4 periodic waits boundary", periodic_state, 0);
  endtask

  task automatic t_doorbell();
    do_reset();
    doorbell = 1;
    step(2);
    check("R8 no ack while off", doorbell_ack, 0);
    doorbell = 0; run_stop = 1; async_en = 1;
    step(1);
    doorbell = 1;
    step(1);
    check("R8 ack pulse", doorbell_ack, 1);
    step(1);
    check("R8 ack gap", doorbell_ack, 0);
    step(1);
    check("R8 ack again while held", doorbell_ack, 1);
    doorbell = 0;
    step(1);
    check("R8 ack clears", doorbell_ack, 0);
    doorbell = 1; async_en = 0;
    step(1);
    check("R8 ack with disable", doorbell_ack, 1);
    check("R3 off with ack", async_state, 0);
    step(1);
    check("R8 no ack after off", doorbell_ack, 0);
    doorbell = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; run_stop = 0; async_en = 0; periodic_en = 0; doorbell = 0;
    frame_idx = '0; async_idle = 1; periodic_idle = 1;
    t_reset();
    t_no_run();
    t_async();
    t_periodic();
    t_halt();
    t_doorbell();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule